// File: doc/BRIEF.md
# Deferred-Ripple Redundant Increment Counter

This block counts increments over the range 0 to 2^N-1 while holding N+1 state bits, so that every step touches only a handful of them. The state is split three ways: a one-bit pending-carry flag, a low field of log2(N) bits kept in reflected Gray code, and a high field holding the remaining N-log2(N) bits in plain binary. The low field is both the least significant digits of the count and a pointer into the high field.

When the low field wraps, the carry into the high field is not applied at once. The flag is raised and the carry walks up the high field one bit per later increment, steered by the pointer, until it is absorbed or leaves the top. The decoded count is always correct, because the pending carry is part of the value.

A parameter picks one of two step rules. The basic rule reads the high bit at the pointer and may change three state bits in one step. The look-back rule also reads the bit just below the pointer and never changes more than two. Every step reports how many state bits it changed.

Top module: `ctr_delayed_carry`

## Requirements
- R1: A synchronous active-low reset clears every state bit, the decoded value and the changed-bit count to zero.
- R2: State bit 0 is the carry flag, bits LOW_W..1 hold the low field in reflected Gray code (LOW_W = ceil(log2 N)), bits N..LOW_W+1 hold the high field in binary; every increment changes exactly one low-field bit.
- R3: After k increments since reset the decoded value equals k mod 2^N, for both step rules; with the basic rule it is low + (high + flag*2^low)*2^LOW_W mod 2^N.
- R4: In a cycle with the increment strobe low, the state is unchanged and the changed-bit count reads 0.
- R5: An increment with the flag clear and the low field at its largest value wraps the low field to zero, sets the flag and leaves the high field untouched.
- R6: Basic rule: an increment with the flag set and high bit [pointer] equal to 1 clears that bit, keeps the flag set and steps the low field.
- R7: Basic rule: an increment with the flag set and high bit [pointer] equal to 0 sets that bit, clears the flag and steps the low field, changing exactly 3 state bits.
- R8: An increment with the flag set and the pointer at or above the high-field width clears the flag, dropping the carry as overflow.
- R9: No increment changes more than 3 state bits under the basic rule, or more than 2 under the look-back rule.
- R10: Look-back rule: with the flag set, if the high bit just below the pointer is 0 (or the pointer is 0) the bit at the pointer is toggled and the flag stays set; if it is 1 the flag is cleared and the high field is left alone. The decoded value adds the pending 2^pointer only when that lower bit is 0 or the pointer is 0.
- R11: The changed-bit count output gives, one cycle after each edge, the number of state bits that edge changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc | input | 1 | Increment strobe, one step per cycle while high |
| state_o | output | N+1 | Raw state: high field, Gray low field, carry flag |
| value_o | output | N | Decoded count modulo 2^N |
| chg_o | output | ceil(log2(N+2)) | State bits changed on the last edge |

## Verification
The bound checker watches every cycle for the per-step invariants: the value moving by exactly one per increment, a single Gray bit change in the low field, the deferred-carry hand-off at the low wrap, the rule-specific ripple moves, the overflow drop, the write bound and the agreement of the changed-bit count with the state. What only the bench's scenarios show is the exact state encoding at chosen counts, the full wrap through 2^N with a ripple running off the top of the high field, the behaviour after a reset issued mid-run, and that both step rules give identical decoded counts from reset onward.

// File: rtl/ctr_dc_pkg.sv
// Package: shared types for the deferred-ripple counter.
// Assumes nothing beyond being compiled before the modules that import it.
package ctr_dc_pkg;

    // Step rule applied while a carry is pending in the high field.
    typedef enum logic {
        MODE_BASIC    = 1'b0,   // read bit at pointer, up to 3 writes
        MODE_LOOKBACK = 1'b1    // also read bit below pointer, up to 2 writes
    } step_mode_e;

endpackage

// File: rtl/ctr_gray_decode.sv
// Module: converts a reflected Gray code word to plain binary.
// Assumes W >= 1; purely combinational.
module ctr_gray_decode #(
    parameter int W = 3
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    // Prefix XOR from the most significant bit downward.
    always_comb begin
        bin_o[W-1] = gray_i[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ gray_i[i];
        end
    end

endmodule

// File: rtl/ctr_gray_step.sv
// Module: produces the Gray word that follows a given binary position.
// Assumes the binary input is the decode of the current Gray word; wraps at 2^W.
module ctr_gray_step #(
    parameter int W = 3
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_nxt_o
);

    logic [W-1:0] bin_nxt;

    // Binary successor, then re-encode to Gray.
    always_comb begin
        bin_nxt    = bin_i + 1'b1;
        gray_nxt_o = bin_nxt ^ (bin_nxt >> 1);
    end

endmodule

// File: rtl/ctr_next_state.sv
// Module: next-state logic of the deferred-ripple counter.
// Assumes HIGH_W < 2^LOW_W so a pending carry always ends before the
// pointer can wrap; MODE picks the basic or the look-back step rule.
module ctr_next_state
    import ctr_dc_pkg::*;
#(
    parameter int         N    = 8,
    parameter step_mode_e MODE = MODE_BASIC,
    parameter int         LOW_W  = $clog2(N),
    parameter int         HIGH_W = N - LOW_W
) (
    input  logic              inc,
    input  logic [N:0]        state_q,
    input  logic [LOW_W-1:0]  ptr,
    output logic [N:0]        state_d
);

    localparam logic [LOW_W-1:0] PTR_MAX  = {LOW_W{1'b1}};
    localparam logic [LOW_W:0]   HIGH_LIM = (LOW_W+1)'(HIGH_W);

    logic              s_flag;
    logic [HIGH_W-1:0] high;
    logic [HIGH_W-1:0] ptr_hot;
    logic [HIGH_W-1:0] below_hot;
    logic              bit_below;
    logic              at_top;
    logic              past_top;
    logic [LOW_W-1:0]  low_nxt;
    logic              s_nxt;
    logic [HIGH_W-1:0] h_nxt;

    assign s_flag = state_q[0];
    assign high   = state_q[N:LOW_W+1];

    // Successor of the Gray low field.
    ctr_gray_step #(.W(LOW_W)) u_low_step (
        .bin_i      (ptr),
        .gray_nxt_o (low_nxt)
    );

    // One-hot selects of the high bit at the pointer and the one below it.
    always_comb begin
        for (int j = 0; j < HIGH_W; j++) begin
            ptr_hot[j]   = (ptr == LOW_W'(j));
            below_hot[j] = ({1'b0, ptr} == (LOW_W+1)'(j + 1));
        end
    end

    assign bit_below = |(high & below_hot);
    assign at_top    = (ptr == PTR_MAX);
    assign past_top  = ({1'b0, ptr} >= HIGH_LIM);

    generate
        if (MODE == MODE_BASIC) begin : g_basic
            logic bit_at;
            assign bit_at = |(high & ptr_hot);

            // Basic rule: clear a 1 and keep rippling, or set a 0 and finish.
            always_comb begin
                s_nxt = s_flag;
                h_nxt = high;
                if (!s_flag) begin
                    if (at_top) s_nxt = 1'b1;
                end else if (past_top) begin
                    s_nxt = 1'b0;
                end else if (bit_at) begin
                    h_nxt = high & ~ptr_hot;
                end else begin
                    h_nxt = high | ptr_hot;
                    s_nxt = 1'b0;
                end
            end
        end else begin : g_lookback
            // Look-back rule: a 1 below the pointer means the ripple settled.
            // At pointer 0 no below bit is selected, so the toggle is taken.
            always_comb begin
                s_nxt = s_flag;
                h_nxt = high;
                if (!s_flag) begin
                    if (at_top) s_nxt = 1'b1;
                end else if (past_top) begin
                    s_nxt = 1'b0;
                end else if (!bit_below) begin
                    h_nxt = high ^ ptr_hot;
                end else begin
                    s_nxt = 1'b0;
                end
            end
        end
    endgenerate

    // Apply the step only on a strobe; otherwise hold.
    always_comb begin
        if (inc) state_d = {h_nxt, low_nxt, s_nxt};
        else     state_d = state_q;
    end

endmodule

// File: rtl/ctr_value_decode.sv
// Module: turns the redundant state into the plain count modulo 2^N.
// Assumes ptr is the binary decode of the low field; a pending carry at a
// pointer at or above HIGH_W weighs 2^N or more and so vanishes modulo 2^N.
module ctr_value_decode
    import ctr_dc_pkg::*;
#(
    parameter int         N    = 8,
    parameter step_mode_e MODE = MODE_BASIC,
    parameter int         LOW_W  = $clog2(N),
    parameter int         HIGH_W = N - LOW_W
) (
    input  logic [N:0]       state_q,
    input  logic [LOW_W-1:0] ptr,
    output logic [N-1:0]     value_o
);

    logic              s_flag;
    logic [HIGH_W-1:0] high;
    logic [HIGH_W-1:0] pend;
    logic [HIGH_W-1:0] high_sum;

    assign s_flag = state_q[0];
    assign high   = state_q[N:LOW_W+1];

    // Weight of the pending carry, one bit per high position.
    generate
        for (genvar j = 0; j < HIGH_W; j++) begin : g_pend
            logic live;
            if (MODE == MODE_BASIC || j == 0) begin : g_always
                assign live = 1'b1;
            end else begin : g_below
                assign live = ~high[j-1];
            end
            assign pend[j] = s_flag & live & (ptr == LOW_W'(j));
        end
    endgenerate

    // High field plus pending carry, low digits from the pointer.
    always_comb begin
        high_sum = high + pend;
        value_o  = {high_sum, ptr};
    end

endmodule

// File: rtl/ctr_delayed_carry.sv
// Module: top of the deferred-ripple redundant increment counter.
// Holds N+1 state bits, steps once per cycle on inc, reports the decoded
// count and the number of state bits each edge changed.
// Assumes N >= 4 and N - ceil(log2 N) < 2^ceil(log2 N).
module ctr_delayed_carry
    import ctr_dc_pkg::*;
#(
    parameter int         N    = 8,
    parameter step_mode_e MODE = MODE_BASIC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc,
    output logic [N:0]               state_o,
    output logic [N-1:0]             value_o,
    output logic [$clog2(N+2)-1:0]   chg_o
);

    localparam int LOW_W  = $clog2(N);
    localparam int HIGH_W = N - LOW_W;
    localparam int CW     = $clog2(N + 2);

    logic [N:0]       state_q;
    logic [N:0]       state_d;
    logic [LOW_W-1:0] ptr;
    logic [CW-1:0]    chg_q;

    // Pointer: binary position held by the Gray low field.
    ctr_gray_decode #(.W(LOW_W)) u_ptr (
        .gray_i (state_q[LOW_W:1]),
        .bin_o  (ptr)
    );

    ctr_next_state #(
        .N(N), .MODE(MODE), .LOW_W(LOW_W), .HIGH_W(HIGH_W)
    ) u_next (
        .inc     (inc),
        .state_q (state_q),
        .ptr     (ptr),
        .state_d (state_d)
    );

    ctr_value_decode #(
        .N(N), .MODE(MODE), .LOW_W(LOW_W), .HIGH_W(HIGH_W)
    ) u_dec (
        .state_q (state_q),
        .ptr     (ptr),
        .value_o (value_o)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Changed-bit count of the step taken at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= CW'($countones(state_d ^ state_q));
    end

    assign state_o = state_q;
    assign chg_o   = chg_q;

endmodule

// File: rtl/ctr_delayed_carry_chk.sv
// Module: assertion checker for ctr_delayed_carry, bound to every instance.
// Recomputes the pointer on its own and checks step invariants each cycle.
module ctr_delayed_carry_chk
    import ctr_dc_pkg::*;
#(
    parameter int         N    = 8,
    parameter step_mode_e MODE = MODE_BASIC
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inc,
    input logic [N:0]             state_o,
    input logic [N-1:0]           value_o,
    input logic [$clog2(N+2)-1:0] chg_o
);

    localparam int LOW_W  = $clog2(N);
    localparam int HIGH_W = N - LOW_W;
    localparam int MAXW   = (MODE == MODE_BASIC) ? 3 : 2;
    localparam logic [LOW_W-1:0] LOW_TOP_G =
        {LOW_W{1'b1}} ^ ({LOW_W{1'b1}} >> 1);

    logic              c_s;
    logic [LOW_W-1:0]  c_low;
    logic [HIGH_W-1:0] c_high;
    logic [LOW_W-1:0]  c_ptr;
    logic [HIGH_W-1:0] c_shift;
    logic              c_bit_at;
    logic              c_bit_below;
    logic              c_in_range;

    assign c_s    = state_o[0];
    assign c_low  = state_o[LOW_W:1];
    assign c_high = state_o[N:LOW_W+1];

    // Independent Gray decode and bit picks for the checks below.
    always_comb begin
        c_ptr[LOW_W-1] = c_low[LOW_W-1];
        for (int i = LOW_W - 2; i >= 0; i--) c_ptr[i] = c_ptr[i+1] ^ c_low[i];
        c_in_range  = (int'(c_ptr) < HIGH_W);
        c_shift     = c_high >> c_ptr;
        c_bit_at    = c_shift[0];
        c_bit_below = (c_ptr != '0) && ((c_high >> (c_ptr - 1'b1)) & 1) != 0;
    end

    p_value_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> value_o == $past(value_o) + 1'b1);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(state_o) && chg_o == '0);

    p_low_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> $countones(c_low ^ $past(c_low)) == 1);

    p_carry_defer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !c_s && c_low == LOW_TOP_G) |=> c_s && c_low == '0 && $stable(c_high));

    p_overflow_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && c_s && !c_in_range) |=> !c_s);

    p_write_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chg_o) <= MAXW);

    p_chg_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(chg_o) == $countones(state_o ^ $past(state_o)));

    generate
        if (MODE == MODE_BASIC) begin : g_basic_props
            p_ripple_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (inc && c_s && c_in_range && c_bit_at) |=>
                    c_s && $countones(c_high) == $countones($past(c_high)) - 1);

            p_ripple_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (inc && c_s && c_in_range && !c_bit_at) |=>
                    !c_s && chg_o == 3 &&
                    $countones(c_high) == $countones($past(c_high)) + 1);
        end else begin : g_lookback_props
            p_lookback_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (inc && c_s && c_in_range && c_bit_below) |=> !c_s && $stable(c_high));

            p_lookback_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (inc && c_s && c_in_range && !c_bit_below) |=>
                    c_s && $countones(c_high ^ $past(c_high)) == 1);
        end
    endgenerate

endmodule

bind ctr_delayed_carry ctr_delayed_carry_chk #(.N(N), .MODE(MODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .state_o (state_o),
    .value_o (value_o),
    .chg_o   (chg_o)
);

// File: tb/ctr_delayed_carry_bench.sv
// Bench: drives both step rules side by side with one strobe, walks a
// vector table of known states, then runs past a full wrap and checks reset.
module ctr_delayed_carry_bench;
    import ctr_dc_pkg::*;

    localparam int N      = 8;
    localparam int CW     = $clog2(N + 2);
    localparam int MOD    = 1 << N;
    localparam int RUN_TO = MOD + N + 36;

    typedef struct packed {
        logic [15:0] cnt;
        logic [8:0]  st_b;
        logic [3:0]  chg_b;
        logic [8:0]  st_l;
        logic [3:0]  chg_l;
    } vec_t;

    // Count reached, basic state/changes, look-back state/changes.
    localparam vec_t VECS [9] = '{
        '{16'd7,  9'h008, 4'd1, 9'h008, 4'd1},
        '{16'd8,  9'h001, 4'd2, 9'h001, 4'd2},
        '{16'd9,  9'h012, 4'd3, 9'h013, 4'd2},
        '{16'd10, 9'h016, 4'd1, 9'h016, 4'd2},
        '{16'd15, 9'h018, 4'd1, 9'h018, 4'd1},
        '{16'd16, 9'h011, 4'd2, 9'h011, 4'd2},
        '{16'd17, 9'h003, 4'd2, 9'h003, 4'd2},
        '{16'd18, 9'h026, 4'd3, 9'h027, 4'd2},
        '{16'd19, 9'h024, 4'd1, 9'h024, 4'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc = 1'b0;
    logic [N:0]    st_b, st_l;
    logic [N-1:0]  val_b, val_l;
    logic [CW-1:0] chg_b, chg_l;

    int checks = 0;
    int failures = 0;
    int cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctr_delayed_carry #(.N(N), .MODE(MODE_BASIC)) u_ctr_delayed_carry (
        .clk(clk), .rst_n(rst_n), .inc(inc),
        .state_o(st_b), .value_o(val_b), .chg_o(chg_b)
    );

    ctr_delayed_carry #(.N(N), .MODE(MODE_LOOKBACK)) u_ctr_delayed_carry_lb (
        .clk(clk), .rst_n(rst_n), .inc(inc),
        .state_o(st_l), .value_o(val_l), .chg_o(chg_l)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // One strobe cycle; returns at the next falling edge with results settled.
    task automatic step();
        inc = 1'b1;
        @(negedge clk);
        inc = 1'b0;
        cnt++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state basic", int'(st_b), 0);
        chk("R1 reset state lookback", int'(st_l), 0);
        chk("R1 reset value", int'(val_b), 0);
        chk("R1 reset chg", int'(chg_b), 0);

        // Table walk.
        for (int v = 0; v < 9; v++) begin
            while (cnt < int'(VECS[v].cnt)) step();
            chk($sformatf("R3 value basic @%0d", cnt), int'(val_b), cnt % MOD);
            chk($sformatf("R3 value lookback @%0d", cnt), int'(val_l), cnt % MOD);
            chk($sformatf("R2 R5 R6 R7 state basic @%0d", cnt), int'(st_b), int'(VECS[v].st_b));
            chk($sformatf("R10 state lookback @%0d", cnt), int'(st_l), int'(VECS[v].st_l));
            chk($sformatf("R11 R7 chg basic @%0d", cnt), int'(chg_b), int'(VECS[v].chg_b));
            chk($sformatf("R11 chg lookback @%0d", cnt), int'(chg_l), int'(VECS[v].chg_l));
        end

        // R4: strobe low leaves state alone and reports no change.
        repeat (4) @(negedge clk);
        chk("R4 hold state basic", int'(st_b), 'h024);
        chk("R4 hold state lookback", int'(st_l), 'h024);
        chk("R4 hold chg basic", int'(chg_b), 0);
        chk("R4 hold chg lookback", int'(chg_l), 0);

        // Long run across the 2^N wrap.
        while (cnt < RUN_TO) begin
            step();
            chk($sformatf("R3 value basic @%0d", cnt), int'(val_b), cnt % MOD);
            chk($sformatf("R3 value lookback @%0d", cnt), int'(val_l), cnt % MOD);
            chk($sformatf("R9 write bound basic @%0d", cnt), int'(chg_b <= 3), 1);
            chk($sformatf("R9 write bound lookback @%0d", cnt), int'(chg_l <= 2), 1);
            if (cnt == MOD + 6) begin
                chk("R8 overflow dropped basic", int'(st_b), 'h00A);
                chk("R8 overflow dropped lookback", int'(st_l), 'h00A);
            end
        end

        // R1: reset in the middle of a run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        chk("R1 mid-run reset state basic", int'(st_b), 0);
        chk("R1 mid-run reset state lookback", int'(st_l), 0);
        chk("R1 mid-run reset chg", int'(chg_l), 0);
        step();
        chk("R3 first step after reset", int'(val_b), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R3 act=%0d exp=%0d", cnt, RUN_TO);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule